// File: doc/BRIEF.md
# Three-Phase PWM Emergency Trip Gate

This block sits between a three-phase PWM generator and the six bridge driver pads. Each phase has a high-side and a complementary low-side signal. An active-low trip input can take all six pads off the bus at once. Software controls the block through two bits in one control word. The enable bit lets the pads drive. The arm bit lets the trip pin act. The bits are read back through the same word.

When the block is armed and enabled and the trip pin falls, the pad enables drop at once through a direct combinational path from the pin. A synchronized copy of the pin then clears the enable bit in hardware. The block keeps the enable bit clear while the synchronized pin is low.

After a trip the arm bit stays set, but it has no effect until the trip latch is cleared. Software must first restore the enable bit. It then writes the arm bit to 0 while enable is 1, and writes it to 1 again. This sequence stops a stale trip from re-arming the block by itself.

Top module: `pwm_trip_gate`

## Requirements
- R1: The control word has enable at bit 0 and arm at bit 1. `rd_data` returns {arm, enable}. After synchronous reset both bits read 0 and every `pad_oe` bit is 0.
- R2: While the enable bit is 0, all six `pad_oe` bits are 0, whatever the level of `trip_n`.
- R3: While the pads are enabled and not tripped, all six `pad_oe` bits are 1. Each `pad_out` bit equals `pwm_in` registered by one clock. The channel order is bit 0 U, bit 1 U low-side, bit 2 V, bit 3 V low-side, bit 4 W, bit 5 W low-side.
- R4: While the block is armed, enabled and not latched, a low level on `trip_n` forces all `pad_oe` bits to 0 in the same cycle, with no clock edge needed.
- R5: `trip_n` passes through two synchronizing flops. If the block is armed and enabled and `trip_n` has been sampled low at three successive rising edges, the enable bit reads 0 after the third of those edges.
- R6: A write of enable = 1 has no effect while the synchronized trip level is low, and a readback shows enable still at 0. A write of enable = 0 always clears the bit.
- R7: While the arm bit is 0, `trip_n` has no effect on `pad_oe` or on the enable bit.
- R8: A trip sets a latch that keeps the trip function inactive. The latch clears only on a write of arm = 0 made while enable already reads 1. A later write of arm = 1 re-arms the trip. The arm bit always reads back as last written.
- R9: When a trip and a register write fall on the same clock edge, the trip wins. Enable reads 0 and the latch is set, while the written arm value still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writes the control word this cycle |
| wr_data | input | 2 | Control word to write: bit 1 arm, bit 0 enable |
| rd_data | output | 2 | Current control word: bit 1 arm, bit 0 enable |
| pwm_in | input | 6 | PWM levels from the generator, in the channel order of R3 |
| trip_n | input | 1 | Active-low emergency trip pin |
| pad_out | output | 6 | Registered pad data levels |
| pad_oe | output | 6 | Pad output enables; 0 means high impedance |

## Verification
The two functions that can meet on one clock edge are the hardware trip clearing the enable bit and a software write to the control word. The bench provokes this in two ways. First, it holds `trip_n` low until the synchronized level falls, with the block armed and enabled. On that same edge it issues a write of arm = 0, or a write that tries to keep enable at 1. The result is judged by the readback and by the latch state that follows. Enable must read 0, and the arm bit must hold the written value. A later re-arm then works only after the full resume sequence. Random traffic mixes writes with trip pulses of varying length, so the same collision also occurs without direction. Every cycle is compared against a bench model of the R1 to R9 rules.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int CTRL_W  = 2;
  localparam int EN_BIT  = 0;
  localparam int ARM_BIT = 1;

  typedef struct packed {
    logic arm;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RESET_VAL;
          else     chain_q[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RESET_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/trip_ctrl.sv
module trip_ctrl
  import pwm_trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              trip_s,
  output ctrl_t             ctrl_q,
  output logic              armed,
  output logic              cut
);
  logic latch_q;
  logic en_nxt, arm_nxt, latch_nxt;

  assign armed = ctrl_q.arm & ~latch_q;
  assign cut   = armed & ctrl_q.en & ~trip_s;

  always_comb begin
    en_nxt = ctrl_q.en;
    if (cut) begin
      en_nxt = 1'b0;
    end else if (wr_en) begin
      if (wr_data[EN_BIT]) en_nxt = trip_s ? 1'b1 : ctrl_q.en;
      else                 en_nxt = 1'b0;
    end
  end

  always_comb begin
    arm_nxt = ctrl_q.arm;
    if (wr_en) arm_nxt = wr_data[ARM_BIT];
  end

  always_comb begin
    latch_nxt = latch_q;
    if (cut)
      latch_nxt = 1'b1;
    else if (wr_en && !wr_data[ARM_BIT] && ctrl_q.en)
      latch_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      ctrl_q.en  <= en_nxt;
      ctrl_q.arm <= arm_nxt;
      latch_q    <= latch_nxt;
    end
  end
endmodule

// File: rtl/trip_outstage.sv
module trip_outstage #(
  parameter int CH = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] pwm_in,
  input  logic          en,
  input  logic          armed,
  input  logic          trip_n,
  output logic [CH-1:0] pad_out,
  output logic [CH-1:0] pad_oe
);
  logic drive_ok;

  assign drive_ok = en & ~(armed & ~trip_n);

  generate
    for (genvar c = 0; c < CH; c++) begin : g_ch
      logic data_q;
      always_ff @(posedge clk) begin
        if (rst) data_q <= 1'b0;
        else     data_q <= pwm_in[c];
      end
      assign pad_out[c] = data_q;
      assign pad_oe[c]  = drive_ok;
    end
  endgenerate
endmodule

// File: rtl/pwm_trip_gate.sv
module pwm_trip_gate
  import pwm_trip_pkg::*;
#(
  parameter int PHASES      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CH         = 2 * PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic [CH-1:0]     pwm_in,
  input  logic              trip_n,
  output logic [CH-1:0]     pad_out,
  output logic [CH-1:0]     pad_oe
);
  logic  trip_s;
  ctrl_t ctrl_q;
  logic  armed;
  logic  cut;

  trip_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (trip_n),
    .dout(trip_s)
  );

  trip_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .trip_s (trip_s),
    .ctrl_q (ctrl_q),
    .armed  (armed),
    .cut    (cut)
  );

  trip_outstage #(.CH(CH)) u_out (
    .clk    (clk),
    .rst    (rst),
    .pwm_in (pwm_in),
    .en     (ctrl_q.en),
    .armed  (armed),
    .trip_n (trip_n),
    .pad_out(pad_out),
    .pad_oe (pad_oe)
  );

  assign rd_data = {ctrl_q.arm, ctrl_q.en};
endmodule

// File: rtl/pwm_trip_gate_chk.sv
module pwm_trip_gate_chk #(
  parameter int CH = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          trip_n,
  input logic [1:0]    rd_data,
  input logic [CH-1:0] pad_oe,
  input logic          armed,
  input logic          trip_s
);
  AST_OE_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !rd_data[0] |-> pad_oe == '0); // R2
  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (pad_oe == '0) || (pad_oe == {CH{1'b1}})); // R3
  AST_ASYNC_HIZ: assert property (@(posedge clk) disable iff (rst)
    (armed && !trip_n) |-> pad_oe == '0); // R4
  AST_TRIP_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
    (armed && rd_data[0] && !trip_s) |=> !rd_data[0]); // R5
  AST_NO_EN_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[0]) |-> $past(trip_s)); // R6
  AST_DISARMED_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[1] && rd_data[0]) |-> pad_oe == {CH{1'b1}}); // R7
endmodule

bind pwm_trip_gate pwm_trip_gate_chk #(.CH(CH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .trip_n (trip_n),
  .rd_data(rd_data),
  .pad_oe (pad_oe),
  .armed  (armed),
  .trip_s (trip_s)
);

// File: tb/pwm_trip_gate_test.sv
module pwm_trip_gate_test;
  localparam int CH = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_data = 2'b00;
  logic [1:0]    rd_data;
  logic [CH-1:0] pwm_in = '0;
  logic          trip_n = 1'b1;
  logic [CH-1:0] pad_out;
  logic [CH-1:0] pad_oe;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  pwm_trip_gate uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_in(pwm_in), .trip_n(trip_n),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2 clk = ~clk;

  // model of R1..R9
  logic m_s1, m_s2, m_en, m_arm, m_lat;
  logic [CH-1:0] m_out;

  always @(posedge clk) begin
    logic armd, cut;
    armd = m_arm & ~m_lat;
    cut  = armd & m_en & ~m_s2;
    if (rst) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_en <= 1'b0; m_arm <= 1'b0;
      m_lat <= 1'b0; m_out <= '0;
    end else begin
      m_s1 <= trip_n;
      m_s2 <= m_s1;
      m_out <= pwm_in;
      if (cut) m_en <= 1'b0;
      else if (wr_en) m_en <= wr_data[0] ? (m_s2 ? 1'b1 : m_en) : 1'b0;
      if (wr_en) m_arm <= wr_data[1];
      if (cut) m_lat <= 1'b1;
      else if (wr_en && !wr_data[1] && m_en) m_lat <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic armd;
    logic [CH-1:0] e_oe;
    string r;
    armd = m_arm & ~m_lat;
    e_oe = {CH{m_en & ~(armd & ~trip_n)}};
    r = !m_en ? "R2" : ((armd && !trip_n) ? "R4" : "R3");
    chk(pad_oe === e_oe, r, 8'(pad_oe), 8'(e_oe));
    chk(pad_out === m_out, "R3", 8'(pad_out), 8'(m_out));
    chk(rd_data === {m_arm, m_en}, cur_req, 8'(rd_data), 8'({m_arm, m_en}));
  endtask

  task automatic drive(input logic we, input logic [1:0] wd, input logic [CH-1:0] pw, input logic tn);
    @(negedge clk);
    wr_en = we; wr_data = wd; pwm_in = pw; trip_n = tn;
    #1;
    compare_model();
  endtask

  task automatic idle(input int n, input logic tn);
    for (int i = 0; i < n; i++) drive(1'b0, 2'b00, CH'($urandom), tn);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(rd_data === 2'b00, "R1", 8'(rd_data), 8'h0);
    chk(pad_oe === '0, "R1", 8'(pad_oe), 8'h0);
    @(negedge clk); rst = 1'b0;

    // R2: disabled pads stay off whatever trip does
    cur_req = "R2";
    idle(2, 1'b0); idle(2, 1'b1);
    chk(pad_oe === '0, "R2", 8'(pad_oe), 8'h0);

    // R3: enable without arm, PWM passes with one clock delay
    cur_req = "R3";
    drive(1'b1, 2'b01, 6'b101010, 1'b1);
    drive(1'b0, 2'b00, 6'b010101, 1'b1);
    chk(pad_out === 6'b101010, "R3", 8'(pad_out), 8'h2a);
    chk(pad_oe === 6'h3f, "R3", 8'(pad_oe), 8'h3f);

    // R7: disarmed, trip pin low has no effect
    cur_req = "R7";
    idle(5, 1'b0);
    chk(rd_data === 2'b01, "R7", 8'(rd_data), 8'h1);
    chk(pad_oe === 6'h3f, "R7", 8'(pad_oe), 8'h3f);
    idle(3, 1'b1);

    // R4/R5: arm, then trip
    cur_req = "R5";
    drive(1'b1, 2'b11, '0, 1'b1);
    drive(1'b0, 2'b00, '0, 1'b0);
    chk(pad_oe === '0, "R4", 8'(pad_oe), 8'h0);
    drive(1'b0, 2'b00, '0, 1'b0);
    chk(rd_data[0] === 1'b1, "R5", 8'(rd_data), 8'h3);
    drive(1'b0, 2'b00, '0, 1'b0);
    chk(rd_data[0] === 1'b1, "R5", 8'(rd_data), 8'h3);
    drive(1'b0, 2'b00, '0, 1'b0);
    chk(rd_data === 2'b10, "R5", 8'(rd_data), 8'h2);

    // R6: enable refused while pin low
    cur_req = "R6";
    drive(1'b1, 2'b11, '0, 1'b0);
    drive(1'b0, 2'b00, '0, 1'b0);
    chk(rd_data[0] === 1'b0, "R6", 8'(rd_data), 8'h2);

    // R8: resume sequence
    cur_req = "R8";
    idle(3, 1'b1);
    drive(1'b1, 2'b11, '0, 1'b1);
    drive(1'b0, 2'b00, '0, 1'b0);           // latched: no cutoff
    chk(pad_oe === 6'h3f, "R8", 8'(pad_oe), 8'h3f);
    idle(3, 1'b0);
    chk(rd_data === 2'b11, "R8", 8'(rd_data), 8'h3);
    drive(1'b1, 2'b01, '0, 1'b1);           // clear latch with en=1
    drive(1'b1, 2'b11, '0, 1'b1);           // re-arm
    drive(1'b0, 2'b00, '0, 1'b0);
    chk(pad_oe === '0, "R8", 8'(pad_oe), 8'h0);
    idle(3, 1'b0);
    chk(rd_data === 2'b10, "R8", 8'(rd_data), 8'h2);

    // R9: trip edge collides with write arm=0
    cur_req = "R9";
    idle(3, 1'b1);
    drive(1'b1, 2'b11, '0, 1'b1);
    drive(1'b1, 2'b01, '0, 1'b1);
    drive(1'b1, 2'b11, '0, 1'b1);
    drive(1'b0, 2'b00, '0, 1'b0);
    drive(1'b0, 2'b00, '0, 1'b0);
    drive(1'b1, 2'b01, '0, 1'b0);           // cut and write on same edge
    drive(1'b0, 2'b00, '0, 1'b0);
    chk(rd_data === 2'b00, "R9", 8'(rd_data), 8'h0);
    idle(3, 1'b1);
    drive(1'b1, 2'b11, '0, 1'b1);           // latch still set: arm inert
    drive(1'b0, 2'b00, '0, 1'b0);
    chk(pad_oe === 6'h3f, "R9", 8'(pad_oe), 8'h3f);
    idle(3, 1'b1);

    // random traffic
    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      logic we, tn;
      we = ($urandom_range(0, 7) == 0);
      tn = (i % 40 < 30) ? 1'b1 : ($urandom_range(0, 3) != 0 ? 1'b0 : 1'b1);
      drive(we, 2'($urandom), CH'($urandom), tn);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule